// File: doc/BRIEF.md
# Two-Wire Clock-Control Register Slave

This block is a slave on a two-wire serial bus (SMBus-style timing, open-drain data). It keeps a small bank of eight-bit control registers for a clock synthesizer. Each bit drives one enable line of a clock output buffer, and all the registers are presented in parallel on one wide output. The system clock samples the serial clock and data lines. START and STOP conditions and clock edges are recovered from the sampled lines. The block drives the data line low only when it acknowledges or when it sends a zero bit.

A transfer starts with the slave's fixed address byte. On a write, the next byte is a command byte. Bit 7 of the command byte selects the mode. Set to 1, it selects a single indexed byte, and bits 6:0 give that index. Set to 0, it selects a block transfer that begins at register 0. In that case bits 6:0 are ignored and a byte-count byte follows the command. Reads are made with a repeated START and the read address, and they use the mode and index of the most recent command. Every register takes its default value at reset, so the clocks run correctly without any bus traffic.

Top module: `clkctl_smb_slave`

## Requirements
- R1: The slave answers only the address bytes D2h (write) and D3h (read), which are 7-bit address 69h with the read flag in bit 0. For any other address it never drives the data line until the next START.
- R2: The slave pulls the data line low during the ninth clock after a matching address byte, after the command byte and after each data byte that is written.
- R3: A command byte with bit 7 = 1 selects single-byte mode. Bits 6:0 are the register index, and a following data byte is written only to that register.
- R4: A command byte with bit 7 = 0 selects block mode. Bits 6:0 are ignored. On a write, the byte after the command is a count byte; it is acknowledged and then discarded. The data bytes after it fill registers 0, 1, 2 and so on in ascending order.
- R5: Every byte on the bus, in either direction, is carried most significant bit first.
- R6: A block read returns a count byte equal to the number of registers first. It then returns the registers from index 0 upward.
- R7: A register changes only when all eight bits of its data byte have been received. A STOP in the middle of a byte leaves that register unchanged and keeps every byte received before it.
- R8: At reset every register is FFh, so every clock-enable output is 1.
- R9: A write to an index at or above the register count is acknowledged and has no effect. A read from such an index returns 00h. This includes bytes past the end of a block.
- R10: After the master answers a read byte with NACK, the slave leaves the data line released until the next START.
- R11: A STOP always returns the slave to idle. A START or repeated START always restarts address decoding, and the mode and index from the last command are kept across a repeated START.
- R12: In single-byte mode, only the first data byte is stored. Later data bytes are acknowledged and discarded. Repeated read bytes all return the same indexed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| clk_en_o | output | NREG*8 | Register bank, register k at bits 8k+7:8k, one enable per clock buffer |

## Verification
A register write and the detection of a bus condition can fall in the same bit window. This happens when the master issues STOP right after a byte completes, or drops the transfer partway through a byte. The bench provokes both. It stops a block write after a full data byte, and in another transfer after four bits of the next byte. It also stops a transfer in the middle of the address byte. A behavioural register image in the bench is compared with the parallel outputs on every clock, so each commit or non-commit is judged in the cycle it lands.

// File: rtl/smbclk_pkg.sv
package smbclk_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_CMD   = 3'd2,
    PH_COUNT = 3'd3,
    PH_WDATA = 3'd4,
    PH_RDATA = 3'd5
  } phase_t;

  // address byte carries the 7-bit device address above the read flag
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // command bit 7 set: single indexed byte
  function automatic logic cmd_single(input logic [7:0] c);
    return c[7];
  endfunction

  // first register touched by a command
  function automatic logic [6:0] cmd_start(input logic [7:0] c);
    return c[7] ? c[6:0] : 7'd0;
  endfunction

  // block pointer advance, saturating at the top code
  function automatic logic [6:0] ptr_next(input logic [6:0] p);
    return (p == 7'h7F) ? p : p + 7'd1;
  endfunction

endpackage

// File: rtl/smb_line_front.sv
module smb_line_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_bit
);
  localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [NS-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[NS-2:0], scl_i};
      sda_sh <= {sda_sh[NS-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s    = scl_sh[NS-1];
  assign sda_s    = sda_sh[NS-1];
  assign sda_bit  = sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int          NREG      = 8,
  parameter logic [7:0]  RESET_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [6:0]        wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [6:0]        rd_idx,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_flat
);
  logic [7:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= RESET_VAL;
      else if (wr_req && wr_idx == 7'(g))
        mem[g] <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = mem[g];
  end

  // indices with no register read as zero
  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NREG; k++)
      if (rd_idx == 7'(k)) rd_data = mem[k];
  end

endmodule

// File: rtl/clkctl_smb_slave.sv
module clkctl_smb_slave
  import smbclk_pkg::*;
#(
  parameter int         NREG        = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] RESET_VAL   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] clk_en_o
);
  localparam logic [7:0] COUNT_BYTE = 8'(NREG);

  logic scl_rise, scl_fall, start_ev, stop_ev, sda_bit;

  phase_t     phase, nxt;
  logic [3:0] bitcnt;
  logic       in_ack, mack, block_mode, wrote_once, cnt_pend, sda_oe;
  logic [7:0] sh;
  logic [6:0] ptr, idx_base;
  logic [7:0] rd_data, rbyte;

  // events brought out by name for the checker
  logic byte_done, ack_end, addr_done, addr_match, ack_go, wr_req, idle_w;
  logic [6:0] wr_idx;

  smb_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_bit(sda_bit)
  );

  assign idle_w     = (phase == PH_IDLE);
  assign byte_done  = scl_fall && !in_ack && (bitcnt == 4'd8) && !idle_w;
  assign ack_end    = scl_fall && in_ack && !idle_w;
  assign addr_done  = byte_done && (phase == PH_ADDR);
  assign addr_match = addr_hit(sh, DEV_ADDR);
  assign ack_go     = byte_done && (phase != PH_RDATA) && (phase != PH_ADDR || addr_match);
  assign wr_req     = byte_done && (phase == PH_WDATA) && (block_mode || !wrote_once);
  assign wr_idx     = ptr;
  assign rbyte      = cnt_pend ? COUNT_BYTE : rd_data;

  smb_regbank #(.NREG(NREG), .RESET_VAL(RESET_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(sh),
    .rd_idx(ptr), .rd_data(rd_data), .regs_flat(clk_en_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      nxt        <= PH_IDLE;
      bitcnt     <= 4'd0;
      in_ack     <= 1'b0;
      mack       <= 1'b0;
      sh         <= 8'h00;
      block_mode <= 1'b1;
      wrote_once <= 1'b0;
      cnt_pend   <= 1'b0;
      ptr        <= 7'd0;
      idx_base   <= 7'd0;
      sda_oe     <= 1'b0;
    end else if (start_ev) begin
      phase  <= PH_ADDR;
      bitcnt <= 4'd0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      phase  <= PH_IDLE;
      bitcnt <= 4'd0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (!idle_w && scl_rise) begin
      if (in_ack) begin
        if (phase == PH_RDATA) mack <= !sda_bit;
      end else if (bitcnt < 4'd8) begin
        bitcnt <= bitcnt + 4'd1;
        if (phase != PH_RDATA) sh <= {sh[6:0], sda_bit};
      end
    end else if (ack_end) begin
      in_ack <= 1'b0;
      bitcnt <= 4'd0;
      if ((phase == PH_RDATA && mack) || (phase != PH_RDATA && nxt == PH_RDATA)) begin
        phase  <= PH_RDATA;
        sh     <= rbyte;
        sda_oe <= ~rbyte[7];
        if (cnt_pend)        cnt_pend <= 1'b0;
        else if (block_mode) ptr <= ptr_next(ptr);
      end else if (phase == PH_RDATA) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        phase  <= nxt;
        sda_oe <= 1'b0;
      end
    end else if (byte_done) begin
      if (phase == PH_RDATA) begin
        sda_oe <= 1'b0;
        in_ack <= 1'b1;
        mack   <= 1'b0;
      end else if (phase == PH_ADDR && !addr_match) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        sda_oe <= 1'b1;
        in_ack <= 1'b1;
        unique case (phase)
          PH_ADDR: begin
            if (sh[0]) begin
              nxt      <= PH_RDATA;
              cnt_pend <= block_mode;
              ptr      <= block_mode ? 7'd0 : idx_base;
            end else begin
              nxt <= PH_CMD;
            end
          end
          PH_CMD: begin
            block_mode <= !cmd_single(sh);
            ptr        <= cmd_start(sh);
            idx_base   <= cmd_start(sh);
            wrote_once <= 1'b0;
            nxt        <= cmd_single(sh) ? PH_WDATA : PH_COUNT;
          end
          PH_COUNT: nxt <= PH_WDATA;
          default: begin
            nxt <= PH_WDATA;
            if (block_mode) ptr <= ptr_next(ptr);
            else            wrote_once <= 1'b1;
          end
        endcase
      end
    end else if (!idle_w && scl_fall && phase == PH_RDATA && !in_ack && bitcnt != 4'd0) begin
      sh     <= {sh[6:0], 1'b0};
      sda_oe <= ~sh[6];
    end
  end

  assign sda_oe_o = sda_oe;

endmodule

// File: rtl/clkctl_smb_chk.sv
module clkctl_smb_chk #(
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe_o,
  input logic [NREG*8-1:0] clk_en_o,
  input logic              idle_w,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              addr_done,
  input logic              addr_match,
  input logic              ack_go,
  input logic              wr_req,
  input logic [6:0]        wr_idx
);
  localparam logic [6:0] LIM = 7'(NREG);
  logic seen_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_rst <= 1'b1;
    else        seen_rst <= 1'b0;
  end

  // R8: while reset is held, every enable reads back as 1
  always @(posedge clk) begin
    if (seen_rst && !rst_n)
      a_r8_reset_defaults: assert (clk_en_o == {NREG*8{1'b1}});
  end

  a_r2_ack_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    ack_go |=> sda_oe_o);

  a_r1_miss_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done && !addr_match |=> idle_w && !sda_oe_o);

  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w |-> !sda_oe_o);

  a_r11_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> idle_w);

  a_r11_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !idle_w);

  a_r9_oor_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !(wr_idx < LIM) |=> $stable(clk_en_o));

  a_r7_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_en_o) |-> $past(wr_req));

endmodule

bind clkctl_smb_slave clkctl_smb_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .clk_en_o(clk_en_o),
  .idle_w(idle_w), .start_ev(start_ev), .stop_ev(stop_ev),
  .addr_done(addr_done), .addr_match(addr_match), .ack_go(ack_go),
  .wr_req(wr_req), .wr_idx(wr_idx)
);

// File: tb/tb_clkctl_smb_slave.sv
module tb_clkctl_smb_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int Q = 6;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] clk_en;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int mism = 0;
  bit pend = 1'b0;
  bit cmp_on = 1'b0;
  bit watch_quiet = 1'b0;
  bit quiet_bad = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_regs [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  clkctl_smb_slave #(.NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .clk_en_o(clk_en)
  );

  function automatic logic [7:0] model_rd(input int idx);
    return (idx < NREG) ? exp_regs[idx] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // register image compared on every clock (R3 R4 R7 R8 R9)
  always @(negedge clk) begin
    if (rst_n && cmp_on && !pend) begin
      for (int k = 0; k < NREG; k++) begin
        if (clk_en[k*8 +: 8] !== exp_regs[k]) begin
          mism++;
          if (mism < 4)
            $display("FAIL R7 per-clock reg%0d actual=%0h expected=%0h", k, clk_en[k*8 +: 8], exp_regs[k]);
        end
      end
    end
    if (watch_quiet && sda_oe) quiet_bad = 1'b1;
  end

  task automatic qw();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    qw(); sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    qw(); sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      qw(); sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int commit, output logic ack);
    if (commit >= 0) pend = 1'b1;
    send_bits(b, 8);
    qw(); sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    ack = (sda_line == 1'b0);
    qw(); scl_m = 1'b0;
    if (commit >= 0) begin
      exp_regs[commit] = b;
      pend = 1'b0;
    end
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      qw(); qw(); scl_m = 1'b1; qw();
      b = {b[6:0], sda_line};
      qw(); scl_m = 1'b0;
    end
    qw(); sda_m = nack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw(); sda_m = 1'b1;
  endtask

  task automatic wr_single(input logic [6:0] idx, input logic [7:0] d0, input string tag);
    logic a;
    bus_start();
    send_byte(8'hD2, -1, a);               chk(a, {tag, " R2 addr ack"}, a, 1);
    send_byte({1'b1, idx}, -1, a);         chk(a, {tag, " R2 cmd ack"}, a, 1);
    send_byte(d0, (idx < NREG) ? int'(idx) : -1, a);
    chk(a, {tag, " R2 data ack"}, a, 1);
    bus_stop();
  endtask

  task automatic rd_single(input logic [6:0] idx, input string tag);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte({1'b1, idx}, -1, a);
    bus_start();
    send_byte(8'hD3, -1, a);               chk(a, {tag, " R11 read addr ack"}, a, 1);
    recv_byte(1'b1, b);
    chk(b == model_rd(int'(idx)), {tag, " R5 byte read"}, b, model_rd(int'(idx)));
    qw();
    chk(!sda_oe, {tag, " R10 released after nack"}, sda_oe, 0);
    bus_stop();
  endtask

  initial begin : main
    logic a;
    logic [7:0] b;
    for (int k = 0; k < NREG; k++) exp_regs[k] = 8'hFF;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(clk_en == {NREG*8{1'b1}}, "R8 reset defaults", clk_en[31:0], 32'hFFFFFFFF);
    chk(!sda_oe, "R8 line released at reset", sda_oe, 0);
    cmp_on = 1'b1;

    // R3 single write, R5 MSB-first read back of an asymmetric value
    wr_single(7'd2, 8'h1E, "R3");
    chk(clk_en[23:16] == 8'h1E, "R3 reg2 written", clk_en[23:16], 8'h1E);
    chk(clk_en[31:24] == 8'hFF, "R3 reg3 untouched", clk_en[31:24], 8'hFF);
    rd_single(7'd2, "R3");

    // R4 block write, nonzero low command bits, count byte discarded
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h05, -1, a);               chk(a, "R4 cmd ack", a, 1);
    send_byte(8'h03, -1, a);               chk(a, "R4 count ack", a, 1);
    send_byte(8'h11, 0, a);
    send_byte(8'h22, 1, a);
    send_byte(8'h33, 2, a);                chk(a, "R2 block data ack", a, 1);
    bus_stop();
    chk(clk_en[7:0] == 8'h11, "R4 reg0 from first data", clk_en[7:0], 8'h11);
    chk(clk_en[23:16] == 8'h33, "R4 reg2 ascending", clk_en[23:16], 8'h33);

    // R6 block read: count then ascending registers, R9 zero past the end
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h00, -1, a);
    bus_start();
    send_byte(8'hD3, -1, a);
    recv_byte(1'b0, b);
    chk(b == 8'(NREG), "R6 count byte", b, NREG);
    for (int k = 0; k <= NREG; k++) begin
      recv_byte(k == NREG, b);
      if (k < NREG) chk(b == exp_regs[k], "R6 block read reg", b, exp_regs[k]);
      else          chk(b == 8'h00, "R9 read past end", b, 0);
    end
    qw();
    chk(!sda_oe, "R10 released after block nack", sda_oe, 0);
    bus_stop();

    // R9 out-of-range single index
    wr_single(7'h40, 8'h00, "R9");
    rd_single(7'h40, "R9");

    // R1 foreign address: no ack, line never driven, nothing written
    watch_quiet = 1'b1; quiet_bad = 1'b0;
    bus_start();
    send_byte(8'hA0, -1, a);
    chk(!a, "R1 foreign address not acked", a, 0);
    send_byte(8'h81, -1, a);
    send_byte(8'h00, -1, a);
    bus_stop();
    watch_quiet = 1'b0;
    chk(!quiet_bad, "R1 line never driven", quiet_bad, 0);
    chk(clk_en[15:8] == 8'h22, "R1 reg1 unchanged", clk_en[15:8], 8'h22);

    // R7 stop part-way through a byte of a block write
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'h02, -1, a);
    send_byte(8'h44, 0, a);
    send_bits(8'h99, 4);
    bus_stop();
    chk(clk_en[7:0] == 8'h44, "R7 full byte kept", clk_en[7:0], 8'h44);
    chk(clk_en[15:8] == 8'h22, "R7 partial byte dropped", clk_en[15:8], 8'h22);

    // R11 stop inside the address byte, then a normal write
    bus_start();
    send_bits(8'hD2, 3);
    bus_stop();
    chk(!sda_oe, "R11 idle after early stop", sda_oe, 0);
    wr_single(7'd5, 8'h5C, "R11");
    chk(clk_en[47:40] == 8'h5C, "R11 write after early stop", clk_en[47:40], 8'h5C);

    // R12 single mode keeps only the first data byte; reads repeat
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h83, -1, a);
    send_byte(8'h66, 3, a);
    send_byte(8'h77, -1, a);
    chk(a, "R12 extra byte acked", a, 1);
    bus_stop();
    chk(clk_en[31:24] == 8'h66, "R12 first byte only", clk_en[31:24], 8'h66);
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h83, -1, a);
    bus_start();
    send_byte(8'hD3, -1, a);
    recv_byte(1'b0, b);
    chk(b == 8'h66, "R12 repeat read 1", b, 8'h66);
    recv_byte(1'b1, b);
    chk(b == 8'h66, "R12 repeat read 2", b, 8'h66);
    bus_stop();

    // R9 block write running past the last register
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'(NREG + 2), -1, a);
    for (int k = 0; k < NREG + 2; k++) begin
      send_byte(8'hC0 + 8'(k), (k < NREG) ? k : -1, a);
      if (k >= NREG) chk(a, "R9 overflow byte acked", a, 1);
    end
    bus_stop();
    chk(clk_en[NREG*8-1 -: 8] == 8'hC0 + 8'(NREG - 1), "R4 last reg of block",
        clk_en[NREG*8-1 -: 8], 8'hC0 + 8'(NREG - 1));

    repeat (20) @(posedge clk);
    chk(mism == 0, "R7 per-clock register image", mism, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule